// File: doc/BRIEF.md
# Serial Flash Erase and Power-Mode Command Front-End

This block is the command-decoding part of a serial NOR flash slave model. It runs on a fast system clock and samples the chip select, serial clock and serial data input lines of a mode-0 serial link. It shifts in an 8-bit opcode, and a 24-bit address for opcodes that carry one. It then decides, at the moment chip select is released, whether the frame was well formed and allowed.

Accepted frames can set the write-enable latch, start a self-timed chip or block erase, or move the part into or out of deep power-down. A plain down-counter models the erase time. The status byte and a fixed identification byte can be shifted out on serial data out. The memory array itself is not modelled. The erase address of a block erase is presented on a port so that a storage model can act on it.

Top module: `sflash_cmd_fe`

## Requirements
- R1: After reset the busy flag, write-enable latch, power-down flag, serial output and erase address are all zero, so the part comes up in standby.
- R2: Opcode 0x06 in a frame of exactly 8 clocks sets the write-enable latch, unless the part is busy or powered down.
- R3: Opcode 0x05 returns the status byte MSB first, starting on the 9th clock. Bit 0 is busy, bit 1 is the write-enable latch, bits 4:2 are the protection inputs and bits 7:5 are zero. In power-down the byte reads as zero.
- R4: Opcode 0x60 or 0xC7 starts a chip erase only when chip select rises after exactly 8 clocks. Any other clock count leaves every output unchanged.
- R5: Opcode 0xD8 followed by a 24-bit address sent MSB first starts a block erase only when the frame is exactly 32 clocks. The address then appears on `erase_addr`.
- R6: Either erase is refused unless the write-enable latch is already set and all three protection inputs are zero.
- R7: A chip erase keeps the busy flag high for exactly CHIP_CYC clock cycles and a block erase for exactly BLK_CYC cycles. The write-enable latch is cleared when the erase starts.
- R8: Opcode 0xB9 in an exact 8-clock frame enters power-down. Deselecting the part without that opcode never enters power-down.
- R9: In power-down every opcode other than 0xAB is ignored.
- R10: Opcode 0xAB with at least 8 clocks leaves power-down when chip select rises. It drives DEV_ID out MSB first from the 9th clock.
- R11: While busy, write-enable, erase and power-down opcodes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| si | input | 1 | Serial data in |
| blk_prot | input | 3 | Block protection bits; any nonzero value blocks erases |
| so | output | 1 | Serial data out |
| wip_o | output | 1 | Erase in progress |
| wel_o | output | 1 | Write-enable latch |
| dpd_o | output | 1 | Deep power-down active |
| erase_addr | output | 24 | Address of the most recent accepted block erase |

## Verification
The erase timer can expire while a status read is in progress, so the busy bit changes under a byte that is being shifted out. The bench starts a chip erase and then issues back-to-back status reads until one shows idle. Each byte must be either the busy pattern or the idle pattern, and once idle is seen busy must not return. Write-enable and power-down frames are also sent while the timer is running, and the bench confirms that neither latch moves.

// File: rtl/sflash_cmd_fe.sv
module sflash_cmd_fe #(
  parameter int CHIP_CYC = 2000,
  parameter int BLK_CYC  = 500,
  parameter logic [7:0] DEV_ID = 8'h15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        si,
  input  logic [2:0]  blk_prot,
  output logic        so,
  output logic        wip_o,
  output logic        wel_o,
  output logic        dpd_o,
  output logic [23:0] erase_addr
);
  localparam int MAXC = (CHIP_CYC > BLK_CYC) ? CHIP_CYC : BLK_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  logic [2:0]    sck_q, csn_q;
  logic [1:0]    si_q;
  logic [5:0]    cnt;
  logic [30:0]   sh;
  logic [7:0]    op;
  logic [TW-1:0] tmr;

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sel      = ~csn_q[1];
  wire cs_rise  = csn_q[1] & ~csn_q[2];
  wire din      = si_q[1];

  wire idle_ok   = !wip_o && !dpd_o;
  wire can_erase = idle_ok && wel_o && (blk_prot == 3'b000);
  wire go_ce   = cs_rise && cnt == 6'd8  && (op == 8'h60 || op == 8'hC7) && can_erase;
  wire go_be   = cs_rise && cnt == 6'd32 && op == 8'hD8 && can_erase;
  wire go_wren = cs_rise && cnt == 6'd8  && op == 8'h06 && idle_ok;
  wire go_dp   = cs_rise && cnt == 6'd8  && op == 8'hB9 && idle_ok;
  wire go_rel  = cs_rise && cnt >= 6'd8  && op == 8'hAB && dpd_o;

  wire [7:0] status   = {3'b000, blk_prot, wel_o, wip_o};
  wire [7:0] out_byte = (op == 8'h05 && !dpd_o) ? status :
                        (op == 8'hAB)           ? DEV_ID : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      csn_q <= '1;
      si_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      csn_q <= {csn_q[1:0], cs_n};
      si_q  <= {si_q[0], si};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
      op  <= '0;
    end else if (!sel) begin
      cnt <= '0;
      op  <= '0;
    end else if (sck_rise) begin
      sh <= {sh[29:0], din};
      if (cnt != 6'd63) cnt <= cnt + 6'd1;
      if (cnt == 6'd7) op <= {sh[6:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) so <= 1'b0;
    else        so <= sel && cnt >= 6'd8 && cnt != 6'd63 && out_byte[~cnt[2:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_o      <= 1'b0;
      tmr        <= '0;
      erase_addr <= '0;
    end else if (go_ce) begin
      wip_o <= 1'b1;
      tmr   <= TW'(CHIP_CYC - 1);
    end else if (go_be) begin
      wip_o      <= 1'b1;
      tmr        <= TW'(BLK_CYC - 1);
      erase_addr <= sh[23:0];
    end else if (wip_o) begin
      if (tmr == '0) wip_o <= 1'b0;
      else           tmr   <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wel_o <= 1'b0;
    else if (go_ce || go_be) wel_o <= 1'b0;
    else if (go_wren)        wel_o <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dpd_o <= 1'b0;
    else if (go_dp)  dpd_o <= 1'b1;
    else if (go_rel) dpd_o <= 1'b0;
  end

  p_erase_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_o) |-> $past(wel_o));
  p_erase_unprotected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_o) |-> $past(blk_prot) == 3'b000);
  p_wel_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_o) |-> !wel_o);
  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_o && tmr != '0) |=> wip_o);
  p_no_erase_in_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_o) |-> !$past(dpd_o));
  p_no_pd_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dpd_o) |-> !$past(wip_o));
  p_wel_frozen_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_o && $past(wip_o)) |-> !$rose(wel_o));
endmodule

// File: tb/sflash_cmd_fe_tb_top.sv
`timescale 1ns/1ps
module sflash_cmd_fe_tb_top;
  localparam int CHIP = 300;
  localparam int BLK  = 120;
  localparam logic [7:0] ID = 8'hC3;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
  logic [2:0] blk_prot = 3'b000;
  logic so, wip_o, wel_o, dpd_o;
  logic [23:0] erase_addr;

  int checks = 0, errors = 0, hc = 0, hc_start = 0;
  logic m_wel = 0, m_wip = 0, m_pd = 0;
  int  m_len = 0;
  logic done = 0;

  sflash_cmd_fe #(.CHIP_CYC(CHIP), .BLK_CYC(BLK), .DEV_ID(ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
    .blk_prot(blk_prot), .so(so), .wip_o(wip_o), .wel_o(wel_o),
    .dpd_o(dpd_o), .erase_addr(erase_addr));

  always #2.5 clk = ~clk;
  always @(negedge clk) if (wip_o) hc++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic [2:0] bp);
    return m_pd ? 8'h00 : {3'b000, bp, m_wel, m_wip};
  endfunction

  task automatic xfer(input logic [39:0] data, input int nbits, output logic [7:0] rx);
    rx = '0;
    cs_n = 1'b0;
    #20;
    for (int i = 0; i < nbits; i++) begin
      si = data[39-i];
      #20;
      if (i >= 8 && i < 16) rx[15-i] = so;
      sclk = 1'b1;
      #20;
      sclk = 1'b0;
    end
    #20 cs_n = 1'b1;
    #60;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < m_len + 60 && wip_o; k++) @(negedge clk);
    check("R7 erase length", hc - hc_start, m_len);
    m_wip = 0;
  endtask

  task automatic do_frame(input logic [7:0] op, input logic [23:0] addr, input int nbits, input bit hold);
    logic [7:0] rx, exp_rx;
    logic rd, ers, ok;
    rd = 0; exp_rx = 0;
    if (op == 8'h05 && nbits >= 16) begin rd = 1; exp_rx = exp_status(blk_prot); end
    if (op == 8'hAB && nbits >= 16) begin rd = 1; exp_rx = ID; end
    ers = ((op == 8'h60 || op == 8'hC7) && nbits == 8) || (op == 8'hD8 && nbits == 32);
    ok  = !m_pd && !m_wip;
    if (!m_wip) hc_start = hc;
    xfer({op, addr, 8'h00}, nbits, rx);
    if (rd) check(op == 8'hAB ? "R10 id readout" : "R3 status readout", rx, exp_rx);
    if (ers && ok && m_wel && blk_prot == 3'b000) begin
      m_wel = 0; m_wip = 1;
      m_len = (op == 8'hD8) ? BLK : CHIP;
      if (op == 8'hD8) check("R5 erase address", erase_addr, addr);
    end else if (op == 8'h06 && nbits == 8 && ok) m_wel = 1;
    else if (op == 8'hB9 && nbits == 8 && ok) m_pd = 1;
    else if (op == 8'hAB && nbits >= 8 && m_pd) m_pd = 0;
    check("R4 R6 R11 busy flag", wip_o, m_wip);
    check("R2 R7 R11 write latch", wel_o, m_wel);
    check("R8 R9 R10 power-down", dpd_o, m_pd);
    if (m_wip && !hold) wait_idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    logic seen_idle;
    logic [7:0] ops [10] = '{8'h06, 8'h06, 8'h05, 8'h60, 8'hC7, 8'hD8, 8'hB9, 8'hAB, 8'h06, 8'h3A};
    void'($urandom(32'd1234));
    #23 rst_n = 1'b1;
    #20;
    check("R1 reset busy", wip_o, 0);
    check("R1 reset wel", wel_o, 0);
    check("R1 reset pd", dpd_o, 0);
    check("R1 reset so", so, 0);
    check("R1 reset addr", erase_addr, 0);

    blk_prot = 3'b101;
    do_frame(8'h05, 0, 16, 0);
    blk_prot = 3'b000;
    do_frame(8'h06, 0, 8, 0);
    do_frame(8'h05, 0, 16, 0);
    do_frame(8'h60, 0, 7, 0);
    do_frame(8'h60, 0, 9, 0);
    do_frame(8'hD8, 24'h123456, 31, 0);
    do_frame(8'hC7, 0, 8, 1);
    do_frame(8'h06, 0, 8, 1);
    do_frame(8'hB9, 0, 8, 1);
    seen_idle = 0;
    for (int n = 0; n < 20 && !seen_idle; n++) begin
      xfer({8'h05, 32'h0}, 16, rx);
      check("R3 status during completion", (rx == 8'h01 || rx == 8'h00), 1);
      if (rx == 8'h00) seen_idle = 1;
    end
    check("R7 busy cleared in status", seen_idle, 1);
    wait_idle();

    do_frame(8'h06, 0, 8, 0);
    blk_prot = 3'b010;
    do_frame(8'h60, 0, 8, 0);
    do_frame(8'hD8, 24'h000100, 32, 0);
    blk_prot = 3'b000;
    do_frame(8'hD8, 24'hA53C0F, 32, 0);
    do_frame(8'hD8, 24'h00FF00, 32, 0);

    do_frame(8'hB9, 0, 8, 0);
    do_frame(8'h06, 0, 8, 0);
    do_frame(8'h05, 0, 16, 0);
    do_frame(8'hAB, 0, 16, 0);
    do_frame(8'h06, 0, 8, 0);
    do_frame(8'hB9, 0, 8, 0);
    do_frame(8'h60, 0, 8, 0);
    do_frame(8'hAB, 0, 8, 0);

    for (int it = 0; it < 120; it++) begin
      logic [7:0] op;
      int nb;
      op = ops[$urandom_range(0, 9)];
      nb = (op == 8'hD8) ? 32 : (op == 8'h05 || op == 8'hAB) ? 16 : 8;
      if ($urandom_range(0, 3) == 0) nb = nb + (($urandom_range(0, 1) == 0) ? -1 : 1);
      blk_prot = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
      do_frame(op, 24'($urandom), nb, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule